// File: doc/BRIEF.md
# Register Block Transfer Sequencer

The sequencer executes one block-transfer operation that moves a group of registers between a 16-entry register file and memory, one register per clock. A caller supplies a start strobe, a base address, a select mask in which bit k enables register k, and four control bits. The control bits choose load or store, whether the address is stepped before or after each access, whether addresses rise or fall, and whether the final address is written back as the new base. This is the mechanism behind multi-register push and pop on a full- or empty-stack, ascending or descending.

Whatever the direction, the selected registers are visited in ascending index order and occupy ascending word addresses. For falling modes the lowest address is computed up front from the population count. Stores read the register file through a combinational read port and drive memory one cycle later. Loads issue reads to a memory with one cycle of read latency, and each returned word is written to the register file. Because the order is ascending, register 15 is always the last one written, so a saved return address can be popped straight into the program counter. A single-cycle done pulse ends the operation, and the written-back base value comes with it.

Top module: `blkxfer_seq`

## Requirements
- R1: Exactly the registers whose bit is set in `sel_mask` (bit k selects register k) are transferred, one per cycle in consecutive cycles, so an operation with n set bits makes n memory accesses.
- R2: Registers go in ascending index order; successive accesses use addresses that rise by 4 bytes, so the lowest selected register always sits at the lowest address.
- R3: The first access address is base when `pre_step`=0 and `step_up`=1, base+4 when `pre_step`=1 and `step_up`=1, base-4n+4 when `pre_step`=0 and `step_up`=0, and base-4n when `pre_step`=1 and `step_up`=0.
- R4: With `is_load`=1 each access raises `mem_rd` only. The word the memory returns one cycle after a read is written to the register file two cycles after that read, with `rf_wr_en` high and `rf_wr_idx` naming the register.
- R5: With `is_load`=0 each access raises `mem_wr` only. `mem_wdata` carries the register-file word for that register, which is read through `rf_rd_idx`/`rf_rd_data` in the cycle before.
- R6: Counting the start-sampling edge as edge 0, `done` is high for exactly one cycle after edge n for a store, after edge n+2 for a load, and after edge 1 for an all-zero mask. An all-zero mask makes no memory access and no register write.
- R7: When `base_wb`=1, `base_wr_en` is high in the `done` cycle with `base_wr_data` equal to base+4n for rising modes, base-4n for falling modes, and base for an empty mask. When `base_wb`=0, `base_wr_en` stays low.
- R8: `busy` is high from the cycle after start acceptance up to, but not including, the `done` cycle. A `start` seen while busy is ignored and changes no output.
- R9: After the synchronous reset, `busy`, `done`, `mem_rd`, `mem_wr`, `rf_wr_en` and `base_wr_en` are low.
- R10: In a load whose mask includes register 15, register 15 receives the final register-file write of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| base_in | input | AW | Base address in bytes |
| sel_mask | input | NREG | Register select mask |
| pre_step | input | 1 | 1: step the address before each access, 0: after |
| step_up | input | 1 | 1: addresses rise, 0: addresses fall |
| base_wb | input | 1 | Write the final address back as the base |
| is_load | input | 1 | 1: memory to registers, 0: registers to memory |
| busy | output | 1 | Operation in progress |
| rf_rd_idx | output | RIDX | Register-file read index |
| rf_rd_data | input | DW | Register-file read data (combinational) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | RIDX | Register-file write index |
| rf_wr_data | output | DW | Register-file write data |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid the cycle after a read |
| done | output | 1 | One-cycle completion pulse |
| base_wr_en | output | 1 | Base writeback strobe |
| base_wr_data | output | AW | New base value |

## Verification
Take the start-sampling edge as edge 0. The k-th access strobe, address and store data are then visible after edge k. A load's k-th register write is visible after edge k+2. `done` and the base writeback are visible after edge n, n+2 or 1, depending on store, load or empty mask. The bench drives `start` at a falling edge and then walks forward one falling edge at a time. At each one it compares every strobe, address, data word, index, `busy` and `done` against the value that this cycle number gives under the rules above. It also checks one extra idle cycle, so a strobe that comes late or repeats is caught as well.

// File: rtl/blkxfer_pkg.sv
`timescale 1ns/1ps
package blkxfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic load;
    logic wb;
  } xfer_mode_t;

endpackage

// File: rtl/blkxfer_addrgen.sv
`timescale 1ns/1ps
// Start and final address for a block transfer, from base, mask and mode.
module blkxfer_addrgen #(
  parameter int NREG  = 16,
  parameter int AW    = 32,
  parameter int ASTEP = 4
) (
  input  logic [AW-1:0]   base,
  input  logic [NREG-1:0] mask,
  input  logic            pre_step,
  input  logic            step_up,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   final_addr
);
  localparam int CW = $clog2(NREG + 1);
  localparam int SH = $clog2(ASTEP);
  localparam logic [AW-1:0] STEP_V = AW'(ASTEP);

  logic [CW-1:0] cnt;
  logic [AW-1:0] span;
  logic [AW-1:0] low;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt = cnt + CW'(mask[i]);
    end
  end

  assign span = AW'(cnt) << SH;
  assign low  = base - span;

  always_comb begin
    if (step_up) begin
      first_addr = pre_step ? (base + STEP_V) : base;
      final_addr = base + span;
    end else begin
      first_addr = pre_step ? low : (low + STEP_V);
      final_addr = low;
    end
  end
endmodule

// File: rtl/blkxfer_pick.sv
`timescale 1ns/1ps
// Lowest-set-bit selector over the remaining register mask.
module blkxfer_pick #(
  parameter int NREG = 16,
  parameter int RIDX = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec,
  output logic [RIDX-1:0] idx,
  output logic            any,
  output logic            last,
  output logic [NREG-1:0] rest
);
  logic [NREG:0]   below;
  logic [NREG-1:0] lowbit;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < NREG; g++) begin : g_chain
    assign below[g+1] = below[g] | vec[g];
    assign lowbit[g]  = vec[g] & ~below[g];
  end

  always_comb begin
    idx = '0;
    for (int g = 0; g < NREG; g++) begin
      if (lowbit[g]) idx = idx | RIDX'(g);
    end
  end

  assign any  = below[NREG];
  assign rest = vec & ~lowbit;
  assign last = any & ~(|rest);
endmodule

// File: rtl/blkxfer_rdpipe.sv
`timescale 1ns/1ps
// Load return path: aligns memory read data with the register index.
module blkxfer_rdpipe #(
  parameter int DW   = 32,
  parameter int RIDX = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_vld,
  input  logic [RIDX-1:0] iss_idx,
  input  logic [DW-1:0]   mem_rdata,
  output logic            wr_en,
  output logic [RIDX-1:0] wr_idx,
  output logic [DW-1:0]   wr_data
);
  logic            pend_q;
  logic [RIDX-1:0] pend_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
    end else begin
      pend_q     <= iss_vld;
      pend_idx_q <= iss_idx;
      wr_en      <= pend_q;
      if (pend_q) begin
        wr_idx  <= pend_idx_q;
        wr_data <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/blkxfer_seq.sv
`timescale 1ns/1ps
// Multi-cycle register block transfer sequencer.
module blkxfer_seq import blkxfer_pkg::*; #(
  parameter int  NREG  = 16,
  parameter int  DW    = 32,
  parameter int  AW    = 32,
  parameter int  ASTEP = 4,
  localparam int RIDX  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   base_in,
  input  logic [NREG-1:0] sel_mask,
  input  logic            pre_step,
  input  logic            step_up,
  input  logic            base_wb,
  input  logic            is_load,
  output logic            busy,
  output logic [RIDX-1:0] rf_rd_idx,
  input  logic [DW-1:0]   rf_rd_data,
  output logic            rf_wr_en,
  output logic [RIDX-1:0] rf_wr_idx,
  output logic [DW-1:0]   rf_wr_data,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic            base_wr_en,
  output logic [AW-1:0]   base_wr_data
);
  localparam logic [AW-1:0] STEP_V = AW'(ASTEP);

  xfer_state_e     state_q;
  xfer_mode_t      mode_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   fin_q;
  logic            drn_q;
  logic [RIDX-1:0] acc_idx_q;

  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   final_addr;
  logic [RIDX-1:0] p_idx;
  logic            p_any;
  logic            p_last;
  logic [NREG-1:0] p_rest;

  blkxfer_addrgen #(.NREG(NREG), .AW(AW), .ASTEP(ASTEP)) u_agen (
    .base       (base_in),
    .mask       (sel_mask),
    .pre_step   (pre_step),
    .step_up    (step_up),
    .first_addr (first_addr),
    .final_addr (final_addr)
  );

  blkxfer_pick #(.NREG(NREG), .RIDX(RIDX)) u_pick (
    .vec  (rem_q),
    .idx  (p_idx),
    .any  (p_any),
    .last (p_last),
    .rest (p_rest)
  );

  blkxfer_rdpipe #(.DW(DW), .RIDX(RIDX)) u_rdp (
    .clk       (clk),
    .rst       (rst),
    .iss_vld   (mem_rd),
    .iss_idx   (acc_idx_q),
    .mem_rdata (mem_rdata),
    .wr_en     (rf_wr_en),
    .wr_idx    (rf_wr_idx),
    .wr_data   (rf_wr_data)
  );

  assign rf_rd_idx = p_idx;
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      mode_q       <= '0;
      rem_q        <= '0;
      addr_q       <= '0;
      fin_q        <= '0;
      drn_q        <= 1'b0;
      acc_idx_q    <= '0;
      mem_addr     <= '0;
      mem_rd       <= 1'b0;
      mem_wr       <= 1'b0;
      mem_wdata    <= '0;
      done         <= 1'b0;
      base_wr_en   <= 1'b0;
      base_wr_data <= '0;
    end else begin
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      done       <= 1'b0;
      base_wr_en <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            rem_q   <= sel_mask;
            addr_q  <= first_addr;
            fin_q   <= final_addr;
            mode_q  <= '{load: is_load, wb: base_wb};
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!p_any) begin
            done         <= 1'b1;
            base_wr_en   <= mode_q.wb;
            base_wr_data <= fin_q;
            state_q      <= ST_IDLE;
          end else begin
            mem_addr  <= addr_q;
            mem_rd    <= mode_q.load;
            mem_wr    <= ~mode_q.load;
            acc_idx_q <= p_idx;
            if (!mode_q.load) mem_wdata <= rf_rd_data;
            addr_q <= addr_q + STEP_V;
            rem_q  <= p_rest;
            if (p_last) begin
              if (mode_q.load) begin
                state_q <= ST_DRAIN;
                drn_q   <= 1'b0;
              end else begin
                done         <= 1'b1;
                base_wr_en   <= mode_q.wb;
                base_wr_data <= fin_q;
                state_q      <= ST_IDLE;
              end
            end
          end
        end
        ST_DRAIN: begin
          if (drn_q) begin
            done         <= 1'b1;
            base_wr_en   <= mode_q.wb;
            base_wr_data <= fin_q;
            state_q      <= ST_IDLE;
          end else begin
            drn_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkxfer_chk.sv
`timescale 1ns/1ps
// Protocol checker for the block transfer sequencer.
module blkxfer_chk #(
  parameter int AW    = 32,
  parameter int ASTEP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          rf_wr_en,
  input logic          base_wr_en,
  input logic [AW-1:0] mem_addr
);
  localparam logic [AW-1:0] STEP_V = AW'(ASTEP);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));                                        // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && $past(mem_rd || mem_wr))
      |-> (mem_addr == $past(mem_addr) + STEP_V));                      // R2

  AST_RFW_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> $past(mem_rd, 2));                                     // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                    // R6

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    base_wr_en |-> done);                                               // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> (!mem_rd && !mem_wr));                         // R8
endmodule

bind blkxfer_seq blkxfer_chk #(.AW(AW), .ASTEP(ASTEP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .rf_wr_en   (rf_wr_en),
  .base_wr_en (base_wr_en),
  .mem_addr   (mem_addr)
);

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_in = '0;
  logic [15:0] sel_mask = '0;
  logic        pre_step = 1'b0, step_up = 1'b0, base_wb = 1'b0, is_load = 1'b0;
  logic        busy;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, base_wr_data;
  logic [31:0] mem_rdata = '0;
  logic        rf_wr_en, mem_rd, mem_wr, done, base_wr_en;
  logic [31:0] salt = 32'h0000_1234;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  blkxfer_seq u0 (
    .clk(clk), .rst(rst), .start(start), .base_in(base_in), .sel_mask(sel_mask),
    .pre_step(pre_step), .step_up(step_up), .base_wb(base_wb), .is_load(is_load),
    .busy(busy), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .base_wr_en(base_wr_en),
    .base_wr_data(base_wr_data)
  );

  function automatic logic [31:0] rf_val(logic [3:0] i, logic [31:0] s);
    return {s[15:0], 12'hA5C, i} ^ {i, 28'h0};
  endfunction

  function automatic logic [31:0] mem_val(logic [29:0] w, logic [31:0] s);
    return {w[15:0], w[15:0]} ^ s ^ 32'h5A5A_0000;
  endfunction

  assign rf_rd_data = rf_val(rf_rd_idx, salt);

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_val(mem_addr[31:2], salt);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] base, input logic [15:0] mask,
                        input bit pre, input bit up, input bit wb, input bit ld,
                        input bit poke);
    int          n;
    int          lat;
    int          ord[16];
    logic [31:0] first, fin, low;
    bit          acc, rfw;
    n = 0;
    for (int i = 0; i < 16; i++) begin
      ord[i] = 0;
      if (mask[i]) begin
        ord[n] = i;
        n++;
      end
    end
    low = base - 32'(4 * n);
    if (up) begin
      first = pre ? base + 32'd4 : base;
      fin   = base + 32'(4 * n);
    end else begin
      first = pre ? low : low + 32'd4;
      fin   = low;
    end
    lat = (n == 0) ? 1 : (ld ? n + 2 : n);
    salt = salt + 32'd1;

    @(negedge clk);
    base_in = base; sel_mask = mask; pre_step = pre; step_up = up;
    base_wb = wb; is_load = ld; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy after start", 32'(busy), 32'd1);
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      start = 1'b0;
      acc = (n > 0) && (c <= n);
      rfw = ld && (n > 0) && (c >= 3) && (c <= n + 2);
      chk("R4 mem_rd", 32'(mem_rd), 32'(acc && ld));
      chk("R5 mem_wr", 32'(mem_wr), 32'(acc && !ld));
      if (acc) begin
        if (c == 1) chk("R3 first address", mem_addr, first);
        else        chk("R2 address step", mem_addr, first + 32'(4 * (c - 1)));
        if (!ld) chk("R5 store data", mem_wdata, rf_val(4'(ord[c-1]), salt));
      end
      chk("R1 rf_wr_en", 32'(rf_wr_en), 32'(rfw));
      if (rfw) begin
        if (c == n + 2 && mask[15]) chk("R10 last write index", 32'(rf_wr_idx), 32'd15);
        else chk("R1 rf_wr_idx", 32'(rf_wr_idx), 32'(ord[c-3]));
        chk("R4 load data", rf_wr_data,
            mem_val(30'((first >> 2) + 32'(c - 3)), salt));
      end
      chk("R6 done timing", 32'(done), 32'(c == lat));
      chk("R7 base_wr_en", 32'(base_wr_en), 32'(c == lat && wb));
      if (c == lat && wb) chk("R7 base value", base_wr_data, fin);
      chk("R8 busy", 32'(busy), 32'(c < lat));
      if (poke && c == 1 && lat >= 3) begin
        base_in = ~base; sel_mask = ~mask; is_load = ~ld; step_up = ~up;
        start = 1'b1;
      end
    end
    @(negedge clk);
    chk("R6 quiet after done", 32'({done, mem_rd, mem_wr, rf_wr_en, base_wr_en}), 32'd0);
    chk("R8 idle after done", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [15:0] msk;
    logic [31:0] base;
    lf = 16'hACE1;
    repeat (5) @(negedge clk);
    chk("R9 reset done",  32'(done), 32'd0);
    chk("R9 reset busy",  32'(busy), 32'd0);
    chk("R9 reset strobes", 32'({mem_rd, mem_wr, rf_wr_en, base_wr_en}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle after reset", 32'({busy, done, mem_rd, mem_wr}), 32'd0);
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 44; k++) begin
        if (k < 16) msk = 16'(1) << k;
        else if (k == 16) msk = 16'h0000;
        else if (k == 17) msk = 16'hFFFF;
        else if (k == 18) msk = 16'h8001;
        else if (k == 19) msk = 16'h11B8;
        else begin
          lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          msk = lf;
        end
        base = (k == 20) ? 32'h0000_0008 : 32'h0000_1000 + 32'(k * 64);
        run_op(base, msk, m[0], m[1], (k % 3) != 0, m[2], (k % 5) == 1);
      end
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule